// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Recognizer

This block watches the clock and data lines of a two-wire serial bus from the slave side. It resynchronizes both lines into the local clock domain and finds bus start and stop conditions. After each start it collects the first byte. The upper seven bits of that byte are the slave address and the lowest bit gives the direction of the transfer. When the byte is complete, the address is compared with a programmable own address and with the reserved extension-code range.

A matching address selects the device. The selection is held for the rest of the transfer and is dropped at the next start or stop condition. A single-cycle interrupt pulse is raised when the address matches, and also when the byte is an extension code. The extension code has its own flag, separate from the selection. The enable input takes effect only after both bus lines have been seen high. This keeps a transfer that is already in progress from being taken for a new start.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: A start condition is SDA falling while SCL stays high, and a stop condition is SDA rising while SCL stays high. Both are judged on two-flop synchronized copies of the lines.
- R2: After a start, SDA is sampled on each of the next eight SCL rising edges, most significant bit first. When the eighth bit arrives, rx_byte_o is loaded with the address in bits 7:1 and the direction bit in bit 0, and rw_o shows that bit 0.
- R3: selected_o goes high when the received 7-bit address equals own_addr_i, and it stays low for any other address.
- R4: ext_code_o goes high when the upper four bits of the received address (rx_byte_o bits 7:4) are all ones. This flag does not depend on the own-address comparison.
- R5: irq_o is a pulse one clock wide. Exactly one pulse is issued for each address byte that matches the own address, is an extension code, or both. No pulse is issued for any other byte.
- R6: Once an address byte is complete, further SCL edges do not change rx_byte_o, selected_o or ext_code_o, and they raise no interrupt. This holds until the next start or stop condition.
- R7: A stop condition clears selected_o and ext_code_o.
- R8: A repeated start clears selected_o and ext_code_o and begins collecting a new address byte. This also applies when the previous byte was only partly received.
- R9: While en_i is low, no condition is detected, no interrupt is raised and selected_o is cleared. After en_i rises, the block starts working only once both synchronized lines have been seen high, so a start that happened before then is not seen.
- R10: After reset, irq_o, selected_o, ext_code_o, rw_o and rx_byte_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| own_addr_i | input | 7 | Programmed own slave address |
| irq_o | output | 1 | One-cycle interrupt on address match or extension code |
| selected_o | output | 1 | Device is addressed, held until next start or stop |
| ext_code_o | output | 1 | Last address byte was an extension code |
| rw_o | output | 1 | Direction bit of the last address byte |
| rx_byte_o | output | 8 | Last received address byte |

## Verification
The hardest case to reach from the ports is a transfer that is already running when the block is enabled. The stimulus creates it by driving a start and lowering both lines while en_i is low. It then raises en_i and clocks the own address onto the bus, so the address arrives with no start that the block could have seen. A second hard case is a repeated start in the middle of a byte. It is reached by sending four ones, which on their own would begin an extension code, and then restarting with the own address. The run also sweeps every 7-bit address against two own-address values, and one of those values lies inside the extension range.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
    localparam int ADDR_BITS     = 7;
    localparam int EXT_PREFIX_W  = 4;
    localparam int SYNC_DEPTH    = 2;
endpackage

// File: rtl/i2c_addr_line_cond.sv
module i2c_addr_line_cond #(
    parameter int STAGES = i2c_addr_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic armed_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [LINES-1:0] raw;
    logic [STAGES-1:0] chain_d [LINES];
    logic [STAGES-1:0] chain_q [LINES];
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] prev_d, prev_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_comb begin
            chain_d[g] = {chain_q[g][STAGES-2:0], raw[g]};
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '1;
            else        chain_q[g] <= chain_d[g];
        end
        assign line_s[g] = chain_q[g][STAGES-1];
    end

    always_comb begin
        prev_d = line_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    logic scl_high;
    assign scl_high   = prev_q[IDX_SCL] & line_s[IDX_SCL];
    assign scl_s_o    = line_s[IDX_SCL];
    assign sda_s_o    = line_s[IDX_SDA];
    assign scl_rise_o = armed_i & ~prev_q[IDX_SCL] & line_s[IDX_SCL];
    assign start_o    = armed_i & scl_high & prev_q[IDX_SDA] & ~line_s[IDX_SDA];
    assign stop_o     = armed_i & scl_high & ~prev_q[IDX_SDA] & line_s[IDX_SDA];

    // R1: start and stop never coincide
    a_r1_excl_cond: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
endmodule

// File: rtl/i2c_addr_enable_gate.sv
module i2c_addr_enable_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic active_o
);
    logic active_d, active_q;

    always_comb begin
        active_d = active_q;
        if (!en_i)                          active_d = 1'b0;
        else if (!active_q && scl_s_i && sda_s_i) active_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_d;
    end

    assign active_o = active_q;

    // R9: arming only from an idle bus
    a_r9_arm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(scl_s_i && sda_s_i && en_i));
    // R9: disable drops activity
    a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !active_q);
endmodule

// File: rtl/i2c_addr_shifter.sv
module i2c_addr_shifter #(
    parameter int BYTE_W = i2c_addr_pkg::ADDR_BITS + 1,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              done_o
);
    typedef struct packed {
        logic              collecting;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              done;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!active_i) begin
            st_d.collecting = 1'b0;
            st_d.cnt        = '0;
        end else if (start_i) begin
            st_d.collecting = 1'b1;
            st_d.cnt        = '0;
        end else if (stop_i) begin
            st_d.collecting = 1'b0;
            st_d.cnt        = '0;
        end else if (scl_rise_i && st_q.collecting) begin
            st_d.shreg = {st_q.shreg[BYTE_W-2:0], sda_i};
            if (st_q.cnt == CNT_W'(BYTE_W - 1)) begin
                st_d.collecting = 1'b0;
                st_d.cnt        = '0;
                st_d.done       = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o = st_q.shreg;
    assign done_o = st_q.done;

    // R2: a completed byte always follows an SCL rising edge
    a_r2_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(scl_rise_i));
    // R8: a start always restarts collection
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_i) |=> (st_q.collecting && st_q.cnt == '0));
endmodule

// File: rtl/i2c_addr_compare.sv
module i2c_addr_compare #(
    parameter int ADDR_W = i2c_addr_pkg::ADDR_BITS,
    parameter int EXT_W  = i2c_addr_pkg::EXT_PREFIX_W,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              match_o,
    output logic              ext_o
);
    logic [ADDR_W-1:0] addr;
    always_comb begin
        addr    = byte_i[BYTE_W-1:1];
        match_o = (addr == own_addr_i);
        ext_o   = (addr[ADDR_W-1 -: EXT_W] == {EXT_W{1'b1}});
    end
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer #(
    parameter int ADDR_W = i2c_addr_pkg::ADDR_BITS,
    parameter int EXT_W  = i2c_addr_pkg::EXT_PREFIX_W,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              irq_o,
    output logic              selected_o,
    output logic              ext_code_o,
    output logic              rw_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    logic scl_s, sda_s, scl_rise, start_c, stop_c, active;
    logic [BYTE_W-1:0] shift_byte;
    logic done, match, ext;

    i2c_addr_line_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .armed_i(active), .scl_s_o(scl_s), .sda_s_o(sda_s),
        .scl_rise_o(scl_rise), .start_o(start_c), .stop_o(stop_c)
    );

    i2c_addr_enable_gate u_gate (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .scl_s_i(scl_s), .sda_s_i(sda_s), .active_o(active)
    );

    i2c_addr_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active_i(active), .start_i(start_c),
        .stop_i(stop_c), .scl_rise_i(scl_rise), .sda_i(sda_s),
        .byte_o(shift_byte), .done_o(done)
    );

    i2c_addr_compare #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_cmp (
        .byte_i(shift_byte), .own_addr_i(own_addr_i),
        .match_o(match), .ext_o(ext)
    );

    typedef struct packed {
        logic [BYTE_W-1:0] rx;
        logic              sel;
        logic              ext;
        logic              irq;
    } sel_t;

    sel_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (!active) begin
            s_d.sel = 1'b0;
            s_d.ext = 1'b0;
        end else if (start_c || stop_c) begin
            s_d.sel = 1'b0;
            s_d.ext = 1'b0;
        end else if (done) begin
            s_d.rx  = shift_byte;
            s_d.sel = match;
            s_d.ext = ext;
            s_d.irq = match | ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o      = s_q.irq;
    assign selected_o = s_q.sel;
    assign ext_code_o = s_q.ext;
    assign rx_byte_o  = s_q.rx;
    assign rw_o       = s_q.rx[0];

    // R5: interrupt lasts one cycle
    a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R3: selection is always announced by an interrupt
    a_r3_sel_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected_o) |-> irq_o);
    // R8: start drops selection
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> !selected_o && !ext_code_o);
    // R7: stop drops selection
    a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !selected_o && !ext_code_o);
    // R9: inactive block holds no selection and no interrupt
    a_r9_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !selected_o && !irq_o);
    // R6: received byte only changes when a byte completes
    a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx_byte_o));
endmodule

// File: tb/tb_i2c_addr_recognizer.sv
module tb_i2c_addr_recognizer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic [6:0] own = 7'h2A;
    logic irq, selected, ext_code, rw;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    i2c_addr_recognizer dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
        .own_addr_i(own), .irq_o(irq), .selected_o(selected),
        .ext_code_o(ext_code), .rw_o(rw), .rx_byte_o(rx_byte)
    );

    always @(posedge clk) begin
        if (!rst_n)   irq_cnt <= 0;
        else if (irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (6) @(negedge clk);
    endtask

    task automatic set_bus(input logic c, input logic d);
        scl = c;
        sda = d;
        hold();
    endtask

    task automatic bus_start();
        set_bus(1'b0, sda);
        set_bus(1'b0, 1'b1);
        set_bus(1'b1, 1'b1);
        set_bus(1'b1, 1'b0);
        set_bus(1'b0, 1'b0);
    endtask

    task automatic bus_stop();
        set_bus(1'b0, 1'b0);
        set_bus(1'b1, 1'b0);
        set_bus(1'b1, 1'b1);
    endtask

    task automatic send_bit(input logic b);
        set_bus(1'b0, b);
        set_bus(1'b1, b);
        set_bus(1'b0, b);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [6:0] owns [2];
        owns[0] = 7'h2A;
        owns[1] = 7'h7C;

        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 irq", irq, 0);
        check("R10 selected", selected, 0);
        check("R10 ext", ext_code, 0);
        check("R10 rw", rw, 0);
        check("R10 rx", rx_byte, 0);
        rst_n = 1'b1;
        hold();

        // R9: disabled block ignores its own address
        base = irq_cnt;
        bus_start();
        send_byte({own, 1'b0});
        hold();
        check("R9 disabled irq", irq_cnt - base, 0);
        check("R9 disabled sel", selected, 0);
        check("R9 disabled rx", rx_byte, 0);
        bus_stop();

        // R9: enable in the middle of a transfer, start unseen
        base = irq_cnt;
        bus_start();
        en = 1'b1;
        hold();
        send_byte({own, 1'b1});
        hold();
        check("R9 busy enable irq", irq_cnt - base, 0);
        check("R9 busy enable sel", selected, 0);
        bus_stop();
        hold();

        // R1 start seen after idle arming, R3 select, R5 one pulse
        base = irq_cnt;
        bus_start();
        send_byte({own, 1'b1});
        hold();
        check("R1 R3 selected after start", selected, 1);
        check("R5 single irq", irq_cnt - base, 1);
        check("R2 rw bit", rw, 1);

        // R6: data phase leaves state alone
        base = irq_cnt;
        send_byte(8'h55);
        send_bit(1'b0);
        send_byte(8'hF0);
        hold();
        check("R6 sel held", selected, 1);
        check("R6 rx held", rx_byte, {own, 1'b1});
        check("R6 no irq", irq_cnt - base, 0);

        // R8: repeated start clears selection
        bus_start();
        check("R8 restart clears sel", selected, 0);
        base = irq_cnt;
        send_byte(8'h10);
        hold();
        check("R8 other addr sel", selected, 0);
        check("R8 other addr rx", rx_byte, 8'h10);
        check("R8 other addr irq", irq_cnt - base, 0);

        // R8: mid-byte restart after an ext-like prefix
        bus_start();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        base = irq_cnt;
        bus_start();
        send_byte({own, 1'b0});
        hold();
        check("R8 midbyte sel", selected, 1);
        check("R8 midbyte ext", ext_code, 0);
        check("R8 midbyte rx", rx_byte, {own, 1'b0});
        check("R8 midbyte irq", irq_cnt - base, 1);

        // R9: disabling drops selection
        en = 1'b0;
        hold();
        check("R9 disable clears sel", selected, 0);
        bus_stop();
        en = 1'b1;
        hold();

        // Sweep all addresses against two own addresses
        for (int k = 0; k < 2; k++) begin
            own = owns[k];
            for (int a = 0; a < 128; a++) begin
                logic [6:0] ad;
                logic r;
                bit m, e;
                ad = 7'(a);
                r  = ad[0] ^ ad[3];
                m  = (ad == own);
                e  = (ad[6:3] == 4'hF);
                base = irq_cnt;
                bus_start();
                send_byte({ad, r});
                hold();
                check("R3 sweep sel", selected, int'(m));
                check("R4 sweep ext", ext_code, int'(e));
                check("R2 sweep rx", rx_byte, {ad, r});
                check("R2 sweep rw", rw, r);
                check("R5 sweep irq", irq_cnt - base, int'(m | e));
                bus_stop();
                check("R7 stop clears sel", selected, 0);
                check("R7 stop clears ext", ext_code, 0);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule